// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block sells one item at a fixed price. Each coin arrives as a one-clock strobe with an 8-bit value. The block adds the coin to a running total. Once the total is equal to or greater than the price, it raises its vend output for one clock, clears the total and waits for the next purchase. No change is returned. The block does not validate coins and does not detect overflow.

The design has two parts. A four-state controller drives two strobes, load and clear, into a datapath. The datapath holds the total register, an unsigned adder and an unsigned less-than comparator. It sends back a single status flag, which is high while the total is less than the price.

Top module: `coin_vend_top`

## Requirements
- R1: The synchronous active-high reset puts the controller in its idle start state (encoding 2'b00) and holds the vend output low. After reset is released, a coin that would reach the price only together with coins inserted before the reset does not cause a vend.
- R2: The start state clears the total to zero. On the following edge it always moves to the coin-wait state (encoding 2'b01).
- R3: In the wait state, a high coin strobe moves the controller to the add state (encoding 2'b10). The coin value must be held through the add state. In that state the total becomes the total plus the coin value, and the controller then returns to the wait state.
- R4: In the wait state, with no coin and a total below the price, the controller stays in the wait state and the total is unchanged. The vend output stays low for as long as the accumulated total is below the price.
- R5: In the wait state, with no coin and a total equal to or greater than the price, the controller moves to the vend state (encoding 2'b11). The vend output is high for exactly one clock, two edges after the edge that accepted the last coin. The controller then goes to the start state.
- R6: A coin strobe sampled while the controller is in the vend state or the start state is ignored and is not added to the total.
- R7: The adder wraps modulo 256. The comparison is unsigned. For example, with a price of 255, coins of 200, 100 and 211 give totals of 200, 44 and 255, and the vend happens only after the third coin.
- R8: With a price of zero and no coins, the controller cycles through the wait, vend and start states, and the vend output is high once every three clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_strobe | input | 1 | High for one clock per inserted coin |
| coin_value | input | 8 | Value of the coin, held through the add cycle |
| item_price | input | 8 | Price of the item, unsigned |
| vend_out | output | 1 | One-clock vend pulse, registered |

## Verification
Two conditions are hard to reach from the ports. The first is a coin that lands while the controller is still in the vend or start state. The bench creates it by holding the strobe high across exactly the two edges that follow a vend. It then shows that this coin was dropped: two further half-price coins are needed before the next vend. The second is wrap-around of the total. The bench reaches it with a sequence whose sum passes 256 while staying below a price of 255, so a lost carry would show up as an early or missing vend.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  localparam int unsigned VAL_W = 8;

  typedef enum logic [1:0] {
    ST_START = 2'b00,
    ST_WAIT  = 2'b01,
    ST_ADD   = 2'b10,
    ST_VEND  = 2'b11
  } vend_state_e;

endpackage

// File: rtl/coin_vend_treg.sv
module coin_vend_treg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (ld) begin
      q <= d;
    end
  end

endmodule

// File: rtl/coin_vend_dp.sv
module coin_vend_dp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tot_clr,
  input  logic         tot_ld,
  input  logic [W-1:0] coin_value,
  input  logic [W-1:0] item_price,
  output logic         tot_below,
  output logic [W-1:0] total
);

  logic [W-1:0] sum_w;

  // Unsigned adder, wraps modulo 2**W
  always_comb begin
    sum_w = total + coin_value;
  end

  coin_vend_treg #(.W(W)) u_treg (
    .clk (clk),
    .rst (rst),
    .clr (tot_clr),
    .ld  (tot_ld),
    .d   (sum_w),
    .q   (total)
  );

  // Unsigned less-than status back to the controller
  always_comb begin
    tot_below = (total < item_price);
  end

endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
  import coin_vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        coin_strobe,
  input  logic        tot_below,
  output logic        tot_clr,
  output logic        tot_ld,
  output logic        vend_q,
  output vend_state_e state_q
);

  vend_state_e state_d;

  always_comb begin
    state_d = state_q;
    tot_clr = 1'b0;
    tot_ld  = 1'b0;
    unique case (state_q)
      ST_START: begin
        tot_clr = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (coin_strobe) begin
          state_d = ST_ADD;
        end else if (!tot_below) begin
          state_d = ST_VEND;
        end
      end
      ST_ADD: begin
        tot_ld  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_VEND: begin
        state_d = ST_START;
      end
      default: begin
        state_d = ST_START;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_START;
      vend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      vend_q  <= (state_d == ST_VEND);
    end
  end

endmodule

// File: rtl/coin_vend_top.sv
module coin_vend_top
  import coin_vend_pkg::*;
#(
  parameter int unsigned W = VAL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         coin_strobe,
  input  logic [W-1:0] coin_value,
  input  logic [W-1:0] item_price,
  output logic         vend_out
);

  logic         tot_clr;
  logic         tot_ld;
  logic         tot_below;
  logic [W-1:0] total;
  vend_state_e  state_q;

  coin_vend_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .coin_strobe (coin_strobe),
    .tot_below   (tot_below),
    .tot_clr     (tot_clr),
    .tot_ld      (tot_ld),
    .vend_q      (vend_out),
    .state_q     (state_q)
  );

  coin_vend_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .tot_clr    (tot_clr),
    .tot_ld     (tot_ld),
    .coin_value (coin_value),
    .item_price (item_price),
    .tot_below  (tot_below),
    .total      (total)
  );

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk
  import coin_vend_pkg::*;
#(
  parameter int unsigned W = VAL_W
) (
  input logic         clk,
  input logic         rst,
  input logic         coin_strobe,
  input logic [W-1:0] coin_value,
  input logic [W-1:0] item_price,
  input logic         vend_out,
  input vend_state_e  state_q,
  input logic [W-1:0] total
);

  p_reset_start_r1: assert property (@(posedge clk)
    rst |=> (state_q == ST_START) && !vend_out);

  p_start_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START) |=> (state_q == ST_WAIT) && (total == '0));

  p_coin_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) && coin_strobe |=> (state_q == ST_ADD));

  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADD) |=>
      (state_q == ST_WAIT) && (total == W'($past(total) + $past(coin_value))));

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) && !coin_strobe && (total < item_price) |=>
      (state_q == ST_WAIT) && $stable(total) && !vend_out);

  p_vend_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vend_out) |-> ($past(state_q) == ST_WAIT) && !$past(coin_strobe)
                        && ($past(total) >= $past(item_price)));

  p_vend_single_r5: assert property (@(posedge clk) disable iff (rst)
    vend_out |=> !vend_out && (state_q == ST_START));

  p_ignore_coin_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VEND) && coin_strobe |=> (state_q == ST_START));

endmodule

bind coin_vend_top coin_vend_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .coin_strobe (coin_strobe),
  .coin_value  (coin_value),
  .item_price  (item_price),
  .vend_out    (vend_out),
  .state_q     (state_q),
  .total       (total)
);

// File: tb/coin_vend_top_bench.sv
`timescale 1ns/1ps
module coin_vend_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_strobe = 1'b0;
  logic [7:0] coin_value = '0;
  logic [7:0] item_price = '0;
  logic       vend_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coin_vend_top u_coin_vend_top (
    .clk         (clk),
    .rst         (rst),
    .coin_strobe (coin_strobe),
    .coin_value  (coin_value),
    .item_price  (item_price),
    .vend_out    (vend_out)
  );

  // {price, coin value, vend expected after this coin}
  localparam int NV = 12;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {8'd50,  8'd20,  1'b0},
    {8'd50,  8'd20,  1'b0},
    {8'd50,  8'd10,  1'b1},
    {8'd50,  8'd25,  1'b0},
    {8'd50,  8'd30,  1'b1},
    {8'd7,   8'd7,   1'b1},
    {8'd100, 8'd60,  1'b0},
    {8'd100, 8'd60,  1'b1},
    {8'd255, 8'd200, 1'b0},
    {8'd255, 8'd100, 1'b0},
    {8'd255, 8'd211, 1'b1},
    {8'd1,   8'd1,   1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Ends at a falling edge with the controller in the wait state
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    coin_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(vend_out == 1'b0, "R1 vend low in reset", int'(vend_out), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Starts and ends at a falling edge in the wait state
  task automatic insert_coin(input logic [7:0] v, input bit exp, input string tag);
    int cnt;
    bit first;
    cnt = 0;
    first = 1'b0;
    coin_strobe = 1'b1;
    coin_value = v;
    @(posedge clk);
    @(negedge clk);
    coin_strobe = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (vend_out) cnt++;
      if (i == 0) first = vend_out;
    end
    check(first == exp, {tag, " vend timing"}, int'(first), int'(exp));
    check(cnt == int'(exp), {tag, " vend count"}, cnt, int'(exp));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit pz;
    int cz;
    item_price = 8'd50;
    do_reset();
    check(vend_out == 1'b0, "R1 vend low after reset", int'(vend_out), 0);

    // Vector walk: R3 accumulation, R4 no early vend, R5 vend pulse, R7 wrap
    for (int k = 0; k < NV; k++) begin
      item_price = VEC[k][16:9];
      insert_coin(VEC[k][8:1], VEC[k][0], $sformatf("R3 R4 R5 R7 vec%0d", k));
    end

    // R1 and R2: a partial total is lost across reset
    item_price = 8'd10;
    insert_coin(8'd5, 1'b0, "R1 pre-reset coin");
    do_reset();
    insert_coin(8'd5, 1'b0, "R2 total cleared by reset");
    insert_coin(8'd5, 1'b1, "R2 second half coin");

    // R6: coin strobe held across the vend and start states is ignored
    coin_strobe = 1'b1;
    coin_value = 8'd10;
    @(posedge clk);
    @(negedge clk);
    coin_strobe = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(vend_out == 1'b1, "R6 setup vend", int'(vend_out), 1);
    coin_strobe = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    coin_strobe = 1'b0;
    check(vend_out == 1'b0, "R6 vend single", int'(vend_out), 0);
    insert_coin(8'd5, 1'b0, "R6 dropped coin not counted");
    insert_coin(8'd5, 1'b1, "R6 next purchase");

    // R8: zero price vends every third clock with no coins
    item_price = 8'd0;
    cz = 0;
    for (int i = 0; i < 9; i++) begin
      @(posedge clk);
      @(negedge clk);
      pz = ((i % 3) == 0);
      if (vend_out) cz++;
      check(vend_out == pz, $sformatf("R8 zero price cycle %0d", i), int'(vend_out), int'(pz));
    end
    check(cz == 3, "R8 zero price count", cz, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule